// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block collects two classes of pending interrupt requests, a software class and an external class, and decides which priority level is currently the most urgent. The software class occupies a contiguous window of request bits, and each bit is renumbered to a level counted upward from 1. The external class keeps its bit index as its level and always outranks the software class. The winning level is compared with the processor's current priority level. A trap is requested only when the winner is strictly more urgent.

When a trap is requested, the block latches two status values in the same clock edge: a bitmap of every pending request in the two windows, each at its own bit position, and the level of the winner. The trap strobe lasts one cycle. It fires again only after the pending set or the current priority level has changed, or after the trap condition has gone away and come back.

Top module: `ilv_arbiter`

## Requirements
- R1: After reset, `trap_o` is 0 and both `isr_o` and `intid_o` are all zeros.
- R2: A software request at bit i, with SW_LO <= i <= SW_HI (default 4..18), gives level i - SW_LO + 1 (1..15). This value appears on `intid_o` one clock edge after the request is presented.
- R3: An external request at bit i, with EXT_LO <= i <= EXT_HI (default 20..30), gives level i.
- R4: If any external request is pending, the highest pending external level wins, whatever software requests are also pending.
- R5: Within one class, the highest pending bit decides the level.
- R6: On a trap, `isr_o` holds the OR of all pending software bits and all pending external bits in range, each at its own position.
- R7: Request bits outside both windows have no effect: they raise no trap and never appear in `isr_o`.
- R8: A trap is raised only when the level is nonzero and strictly greater than `cur_ipl`. An equal level raises nothing.
- R9: `trap_o` is a one-cycle pulse. It does not fire again while `sw_req`, `ext_req` and `cur_ipl` stay unchanged.
- R10: While the trap condition holds, a change to `cur_ipl` or to the pending set raises a new pulse with freshly captured status.
- R11: `isr_o` and `intid_o` change only on the edge that raises `trap_o`, and otherwise keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_req | input | REQ_W | Software request register contents |
| ext_req | input | REQ_W | External request lines |
| cur_ipl | input | LVL_W | Current processor priority level |
| trap_o | output | 1 | One-cycle trap request |
| isr_o | output | REQ_W | Pending-request summary captured at trap |
| intid_o | output | LVL_W | Winning level captured at trap |

## Verification
An error in the re-arm snapshot shows up on `trap_o` in the cycle right after the inputs settle. It appears either as a second pulse while the inputs are stable, or as a missing pulse after `cur_ipl` or the pending set changes. A wrong level mapping or a wrong window mask appears on `intid_o` or `isr_o` on the first trap that involves the affected bit, one edge after the request is applied. Sweeping every in-range bit on its own, and then the out-of-range bits, exposes such faults within a single scenario.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   localparam int LVL_W = 5;
   typedef logic [LVL_W-1:0] lvl_t;

   // Bits lo..hi set, the rest clear.
   function automatic logic [63:0] range_mask(input int lo, input int hi);
      logic [63:0] m;
      m = '0;
      for (int b = 0; b < 64; b++) begin
         if (b >= lo && b <= hi) m[b] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/ilv_prio_enc.sv
module ilv_prio_enc #(
   parameter int W    = 8,
   parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int b = 0; b < W; b++) begin
         if (vec[b]) begin
            any = 1'b1;
            idx = IDX_W'(b);
         end
      end
   end
endmodule

// File: rtl/ilv_level_merge.sv
module ilv_level_merge
   import ilv_pkg::*;
#(
   parameter int REQ_W  = 32,
   parameter int SW_LO  = 4,
   parameter int SW_HI  = 18,
   parameter int EXT_LO = 20,
   parameter int EXT_HI = 30
) (
   input  logic [REQ_W-1:0] sw_req,
   input  logic [REQ_W-1:0] ext_req,
   output lvl_t             lvl,
   output logic [REQ_W-1:0] sum
);
   localparam int SW_N  = SW_HI - SW_LO + 1;
   localparam int EXT_N = EXT_HI - EXT_LO + 1;
   localparam int SW_IW  = (SW_N > 1) ? $clog2(SW_N) : 1;
   localparam int EXT_IW = (EXT_N > 1) ? $clog2(EXT_N) : 1;
   localparam logic [63:0] SW_M64  = range_mask(SW_LO, SW_HI);
   localparam logic [63:0] EXT_M64 = range_mask(EXT_LO, EXT_HI);
   localparam logic [REQ_W-1:0] SW_MASK  = SW_M64[REQ_W-1:0];
   localparam logic [REQ_W-1:0] EXT_MASK = EXT_M64[REQ_W-1:0];

   logic              sw_any, ext_any;
   logic [SW_IW-1:0]  sw_idx;
   logic [EXT_IW-1:0] ext_idx;

   assign sum = (sw_req & SW_MASK) | (ext_req & EXT_MASK);

   ilv_prio_enc #(.W(SW_N), .IDX_W(SW_IW)) u_sw_enc (
      .vec (sum[SW_HI:SW_LO]),
      .any (sw_any),
      .idx (sw_idx)
   );

   ilv_prio_enc #(.W(EXT_N), .IDX_W(EXT_IW)) u_ext_enc (
      .vec (sum[EXT_HI:EXT_LO]),
      .any (ext_any),
      .idx (ext_idx)
   );

   always_comb begin
      if (ext_any)
         lvl = lvl_t'(ext_idx) + lvl_t'(EXT_LO);
      else if (sw_any)
         lvl = lvl_t'(sw_idx) + lvl_t'(1);
      else
         lvl = '0;
   end
endmodule

// File: rtl/ilv_trap_gate.sv
module ilv_trap_gate
   import ilv_pkg::*;
#(
   parameter int REQ_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lvl_t             lvl,
   input  logic [REQ_W-1:0] sum,
   input  lvl_t             cur_ipl,
   output logic             trap_o,
   output logic [REQ_W-1:0] isr_o,
   output lvl_t             intid_o
);
   logic             cond, same, fire;
   logic             last_cond;
   logic [REQ_W-1:0] last_sum;
   lvl_t             last_ipl;

   assign cond = (lvl != '0) && (lvl > cur_ipl);
   assign same = last_cond && (last_sum == sum) && (last_ipl == cur_ipl);
   assign fire = cond && !same;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_cond <= 1'b0;
         last_sum  <= '0;
         last_ipl  <= '0;
         trap_o    <= 1'b0;
         isr_o     <= '0;
         intid_o   <= '0;
      end else begin
         last_cond <= cond;
         last_sum  <= sum;
         last_ipl  <= cur_ipl;
         trap_o    <= fire;
         if (fire) begin
            isr_o   <= sum;
            intid_o <= lvl;
         end
      end
   end
endmodule

// File: rtl/ilv_arbiter.sv
module ilv_arbiter
   import ilv_pkg::*;
#(
   parameter int REQ_W  = 32,
   parameter int SW_LO  = 4,
   parameter int SW_HI  = 18,
   parameter int EXT_LO = 20,
   parameter int EXT_HI = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REQ_W-1:0] sw_req,
   input  logic [REQ_W-1:0] ext_req,
   input  logic [LVL_W-1:0] cur_ipl,
   output logic             trap_o,
   output logic [REQ_W-1:0] isr_o,
   output logic [LVL_W-1:0] intid_o
);
   if (SW_HI >= EXT_LO) begin : g_overlap
      $error("software window must lie below the external window");
   end
   if (EXT_HI >= (1 << LVL_W) || EXT_HI >= REQ_W || REQ_W > 64) begin : g_range
      $error("external window exceeds level or request width");
   end
   if (SW_HI - SW_LO + 1 >= EXT_LO) begin : g_rank
      $error("software levels must stay below external levels");
   end

   lvl_t             lvl;
   logic [REQ_W-1:0] sum;

   ilv_level_merge #(
      .REQ_W(REQ_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
      .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
   ) u_merge (
      .sw_req  (sw_req),
      .ext_req (ext_req),
      .lvl     (lvl),
      .sum     (sum)
   );

   ilv_trap_gate #(.REQ_W(REQ_W)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl),
      .sum     (sum),
      .cur_ipl (cur_ipl),
      .trap_o  (trap_o),
      .isr_o   (isr_o),
      .intid_o (intid_o)
   );
endmodule

// File: rtl/ilv_arbiter_chk.sv
module ilv_arbiter_chk
   import ilv_pkg::*;
#(
   parameter int REQ_W  = 32,
   parameter int SW_LO  = 4,
   parameter int SW_HI  = 18,
   parameter int EXT_LO = 20,
   parameter int EXT_HI = 30
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REQ_W-1:0] sw_req,
   input logic [REQ_W-1:0] ext_req,
   input logic [LVL_W-1:0] cur_ipl,
   input logic             trap_o,
   input logic [REQ_W-1:0] isr_o,
   input logic [LVL_W-1:0] intid_o
);
   localparam logic [63:0] ALL_M64 = range_mask(SW_LO, SW_HI) | range_mask(EXT_LO, EXT_HI);
   localparam logic [63:0] EXT_M64 = range_mask(EXT_LO, EXT_HI);
   localparam logic [REQ_W-1:0] IN_MASK  = ALL_M64[REQ_W-1:0];
   localparam logic [REQ_W-1:0] EXT_MASK = EXT_M64[REQ_W-1:0];

   // R8
   trap_above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (intid_o > $past(cur_ipl)));

   // R9
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && $stable(cur_ipl) && $stable(sw_req) && $stable(ext_req)) |=> !trap_o);

   // R11
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_o |-> ($stable(isr_o) && $stable(intid_o)));

   // R7
   isr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_o & ~IN_MASK) == '0);

   // R4
   ext_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && (($past(ext_req) & EXT_MASK) != '0)) |-> (intid_o >= LVL_W'(EXT_LO)));
endmodule

bind ilv_arbiter ilv_arbiter_chk #(
   .REQ_W(REQ_W), .SW_LO(SW_LO), .SW_HI(SW_HI), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ext_req(ext_req),
   .cur_ipl(cur_ipl), .trap_o(trap_o), .isr_o(isr_o), .intid_o(intid_o)
);

// File: tb/sim_ilv_arbiter.sv
module sim_ilv_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] sw_req = '0;
   logic [31:0] ext_req = '0;
   logic [4:0]  cur_ipl = '0;
   logic        trap_o;
   logic [31:0] isr_o;
   logic [4:0]  intid_o;
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   ilv_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ext_req(ext_req),
      .cur_ipl(cur_ipl), .trap_o(trap_o), .isr_o(isr_o), .intid_o(intid_o)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // Drive at a falling edge and wait one cycle; outputs then reflect the edge between.
   task automatic step(input logic [31:0] s, input logic [31:0] e, input logic [4:0] ipl);
      sw_req = s; ext_req = e; cur_ipl = ipl;
      @(negedge clk);
   endtask

   task automatic idle();
      step(32'h0, 32'h0, 5'd0);
   endtask

   task automatic t_reset();
      chk("R1 trap", {31'd0, trap_o}, 32'd0);
      chk("R1 isr", isr_o, 32'd0);
      chk("R1 intid", {27'd0, intid_o}, 32'd0);
   endtask

   task automatic t_sw_levels();
      for (int i = 4; i <= 18; i++) begin
         idle();
         step(32'd1 << i, 32'h0, 5'd0);
         chk("R2 trap", {31'd0, trap_o}, 32'd1);
         chk("R2 intid", {27'd0, intid_o}, 32'(i - 3));
         chk("R6 isr", isr_o, 32'd1 << i);
      end
   endtask

   task automatic t_ext_levels();
      for (int i = 20; i <= 30; i++) begin
         idle();
         step(32'h0, 32'd1 << i, 5'd0);
         chk("R3 trap", {31'd0, trap_o}, 32'd1);
         chk("R3 intid", {27'd0, intid_o}, 32'(i));
      end
   endtask

   task automatic t_ext_over_sw();
      idle();
      step(32'h0004_0010, 32'h0010_0000, 5'd0);
      chk("R4 intid", {27'd0, intid_o}, 32'd20);
      chk("R6 isr", isr_o, 32'h0014_0010);
   endtask

   task automatic t_highest();
      idle();
      step(32'h0002_0220, 32'h0, 5'd0);
      chk("R5 sw intid", {27'd0, intid_o}, 32'd14);
      idle();
      step(32'h0, 32'h0220_0000, 5'd0);
      chk("R5 ext intid", {27'd0, intid_o}, 32'd25);
      chk("R6 isr", isr_o, 32'h0220_0000);
   endtask

   task automatic t_out_of_range();
      idle();
      step(32'h0000_0010, 32'h0, 5'd0);
      idle();
      step(32'h8008_000F, 32'h8008_000F, 5'd0);
      chk("R7 trap", {31'd0, trap_o}, 32'd0);
      chk("R11 isr hold", isr_o, 32'h0000_0010);
      chk("R11 intid hold", {27'd0, intid_o}, 32'd1);
      step(32'h8008_002F, 32'h8008_000F, 5'd0);
      chk("R7 trap in", {31'd0, trap_o}, 32'd1);
      chk("R7 isr", isr_o, 32'h0000_0020);
      chk("R7 intid", {27'd0, intid_o}, 32'd2);
   endtask

   task automatic t_threshold();
      idle();
      step(32'd1 << 10, 32'h0, 5'd7);
      chk("R8 equal", {31'd0, trap_o}, 32'd0);
      step(32'd1 << 10, 32'h0, 5'd9);
      chk("R8 above", {31'd0, trap_o}, 32'd0);
      step(32'd1 << 10, 32'h0, 5'd6);
      chk("R8 below", {31'd0, trap_o}, 32'd1);
      chk("R8 intid", {27'd0, intid_o}, 32'd7);
      step(32'd1 << 10, 32'h0, 5'd6);
      chk("R9 stable", {31'd0, trap_o}, 32'd0);
      step(32'd1 << 10, 32'h0, 5'd6);
      chk("R9 stable2", {31'd0, trap_o}, 32'd0);
      step(32'd1 << 10, 32'h0, 5'd5);
      chk("R10 ipl change", {31'd0, trap_o}, 32'd1);
      step(32'h0000_0C00, 32'h0, 5'd5);
      chk("R10 pend change", {31'd0, trap_o}, 32'd1);
      chk("R10 intid", {27'd0, intid_o}, 32'd8);
      chk("R10 isr", isr_o, 32'h0000_0C00);
      step(32'h0000_0C00, 32'h0, 5'd5);
      chk("R9 no refire", {31'd0, trap_o}, 32'd0);
      chk("R11 hold", {27'd0, intid_o}, 32'd8);
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      $display("FAIL watchdog");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sw_levels();
      t_ext_levels();
      t_ext_over_sw();
      t_highest();
      t_out_of_range();
      t_threshold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule